// File: doc/BRIEF.md
# Configurable Pin Function Selector

This block decides, pin by pin, what each line of a bank of general-purpose pins does. Every pin has its own 4-bit function code. The code is captured while reset is held, so the choice is fixed for the whole session. The choices are:

- a passive input that rests at its pull-up level;
- a constant high or constant low drive;
- a software-controlled I/O bit;
- a transmit-enable level for a line driver;
- an active-low power-enable flag that follows the suspend state;
- active-low activity strobes for transmitted bytes, received bytes, or either;
- an active-low sleep indicator;
- one of three divided copies of the system clock.

The selector is placed between a serial core and the pad ring. From the serial core it takes byte strobes, a transmit-in-progress level and the suspend and configured flags. For each pin it returns a value and an output enable to the pad. It also returns a synchronised copy of the pad levels, which software reads when a pin is in software I/O mode.

Activity strobes are stretched to a programmable number of cycles so that an indicator LED can show them. In a typical tie-off, most pins use the pulled-up input code, one pin carries power enable and one carries combined activity.

Top module: `pin_func_sel`

## Requirements
- R1: Function codes are loaded on every clock edge while rst_ni is low and on the first edge after its release. After that, changes on func_code_i have no effect on any pin.
- R2: Code 0 (pulled-up input) and the unused codes 13, 14 and 15 give pin_oe_o=0 and pin_o=1. In these codes the software I/O inputs have no effect.
- R3: Code 1 drives the pin high and code 2 drives it low, both with pin_oe_o=1.
- R4: With code 3 (software I/O), pin_o equals soft_out_i and pin_oe_o equals soft_oe_i for that pin, in the same cycle.
- R5: pin_rd_o shows each pin_in_i bit after exactly two clock edges.
- R6: Code 4 (transmit enable) drives tx_active_i, delayed by one clock, with pin_oe_o=1. The output is 0 out of reset.
- R7: Code 5 (power enable, active low) drives 0 one clock after configured_i=1 with suspend_i=0. Otherwise it drives 1, and it is 1 out of reset.
- R8: Codes 6, 7 and 8 are active-low activity strobes. Code 6 responds to tx_byte_i, code 7 to rx_byte_i, and code 8 to either. A one-cycle event makes the pin low from the next cycle for exactly ACT_HOLD cycles. A new event during a strobe restarts the full count.
- R9: Code 9 (sleep, active low) drives the inverse of suspend_i, delayed by one clock. It is 1 out of reset.
- R10: Codes 10, 11 and 12 output the clock divided by 4, 8 and 16, with equal high and low halves. Each divider starts low on reset release, so output k at cycle n after release is bit (1+k) of n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; codes are captured while low |
| func_code_i | input | NUM_PINS*4 | Per-pin function codes, pin k in bits [4k+3:4k] |
| tx_byte_i | input | 1 | One-cycle strobe per transmitted byte |
| rx_byte_i | input | 1 | One-cycle strobe per received byte |
| tx_active_i | input | 1 | High while the serial core is transmitting |
| suspend_i | input | 1 | Bus suspend state |
| configured_i | input | 1 | Device has been configured by the host |
| soft_out_i | input | NUM_PINS | Software output values |
| soft_oe_i | input | NUM_PINS | Software output directions (1 = drive) |
| pin_in_i | input | NUM_PINS | Pad input levels |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe_o | output | NUM_PINS | Pad output enables |
| pin_rd_o | output | NUM_PINS | Synchronised pad levels |

## Verification
Some properties are checked on every cycle by the assertions:

- the fixed-drive, passive-input and software I/O mappings for each pin;
- that the captured codes hold still once the capture window closes;
- that an activity counter reloads on each event;
- the power-flag response to the configured and suspend inputs;
- the two-stage synchroniser;
- the divider wrap.

Other behaviour only the bench scenarios can show. These are the exact strobe lengths and their extension on a retrigger, the phase and half-periods of the three divided clocks from reset release, and the reset levels of each status function. They also cover the separation between transmit, receive and combined strobes, and the fact that codes applied after reset leave the pins untouched.

// File: rtl/pin_func_pkg.sv
`timescale 1ns/1ps
package pin_func_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CLK_TAPS = 3;

  typedef enum logic [CODE_W-1:0] {
    FN_PULL_IN   = 4'd0,
    FN_DRV_HI    = 4'd1,
    FN_DRV_LO    = 4'd2,
    FN_SOFT_IO   = 4'd3,
    FN_TX_EN     = 4'd4,
    FN_PWR_N     = 4'd5,
    FN_TX_ACT_N  = 4'd6,
    FN_RX_ACT_N  = 4'd7,
    FN_ANY_ACT_N = 4'd8,
    FN_SLEEP_N   = 4'd9,
    FN_CLK_D4    = 4'd10,
    FN_CLK_D8    = 4'd11,
    FN_CLK_D16   = 4'd12
  } pin_fn_e;

  typedef struct packed {
    logic                tx_en;
    logic                pwr_n;
    logic                sleep_n;
    logic                tx_act_n;
    logic                rx_act_n;
    logic                any_act_n;
    logic [CLK_TAPS-1:0] clk_div;
  } pin_status_t;
endpackage

// File: rtl/act_stretch.sv
`timescale 1ns/1ps
module act_stretch #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic act_no
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  // Event reloads the full count, so a retrigger extends the strobe.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (evt_i)         cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign act_no = (cnt_q == '0);

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (cnt_q == CW'(HOLD)));

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && cnt_q == '0) |=> act_no);
endmodule

// File: rtl/clk_divider.sv
`timescale 1ns/1ps
module clk_divider #(
  parameter int unsigned LOW_TAP  = 1,
  parameter int unsigned NUM_TAPS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] taps_o
);
  localparam int unsigned CW = LOW_TAP + NUM_TAPS;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign taps_o[k] = cnt_q[LOW_TAP+k];
  end

  assert_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (taps_o == '0));
endmodule

// File: rtl/sync_2ff.sv
`timescale 1ns/1ps
module sync_2ff #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      rd_q   <= '0;
    end else begin
      meta_q <= d_i;
      rd_q   <= meta_q;
    end
  end

  assign q_o = rd_q;

  assert_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_q == $past(meta_q)));
endmodule

// File: rtl/pin_cell.sv
`timescale 1ns/1ps
module pin_cell
  import pin_func_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  pin_status_t       st_i,
  input  logic              soft_out_i,
  input  logic              soft_oe_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  always_comb begin
    pin_o    = 1'b1;
    pin_oe_o = 1'b1;
    case (pin_fn_e'(code_i))
      FN_DRV_HI:    pin_o = 1'b1;
      FN_DRV_LO:    pin_o = 1'b0;
      FN_SOFT_IO: begin
        pin_o    = soft_out_i;
        pin_oe_o = soft_oe_i;
      end
      FN_TX_EN:     pin_o = st_i.tx_en;
      FN_PWR_N:     pin_o = st_i.pwr_n;
      FN_TX_ACT_N:  pin_o = st_i.tx_act_n;
      FN_RX_ACT_N:  pin_o = st_i.rx_act_n;
      FN_ANY_ACT_N: pin_o = st_i.any_act_n;
      FN_SLEEP_N:   pin_o = st_i.sleep_n;
      FN_CLK_D4:    pin_o = st_i.clk_div[0];
      FN_CLK_D8:    pin_o = st_i.clk_div[1];
      FN_CLK_D16:   pin_o = st_i.clk_div[2];
      // Pulled-up input and all unused codes: released, resting high.
      default: begin
        pin_o    = 1'b1;
        pin_oe_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pin_func_sel.sv
`timescale 1ns/1ps
module pin_func_sel
  import pin_func_pkg::*;
#(
  parameter int unsigned NUM_PINS = 10,
  parameter int unsigned ACT_HOLD = 8,
  parameter int unsigned DIV_TAP  = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS*CODE_W-1:0] func_code_i,
  input  logic                       tx_byte_i,
  input  logic                       rx_byte_i,
  input  logic                       tx_active_i,
  input  logic                       suspend_i,
  input  logic                       configured_i,
  input  logic [NUM_PINS-1:0]        soft_out_i,
  input  logic [NUM_PINS-1:0]        soft_oe_i,
  input  logic [NUM_PINS-1:0]        pin_in_i,
  output logic [NUM_PINS-1:0]        pin_o,
  output logic [NUM_PINS-1:0]        pin_oe_o,
  output logic [NUM_PINS-1:0]        pin_rd_o
);
  localparam int unsigned NUM_ACT = 3;

  logic                             in_rst_q;
  logic [NUM_PINS-1:0][CODE_W-1:0]  code_q;
  logic                             tx_en_q, pwr_n_q, sleep_n_q;
  logic [NUM_ACT-1:0]               act_evt, act_n;
  logic [CLK_TAPS-1:0]              div_taps;
  pin_status_t                      st;

  // Reset seen in the clock domain; keeps rst_ni off the capture data path.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (in_rst_q) code_q <= func_code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q   <= 1'b0;
      pwr_n_q   <= 1'b1;
      sleep_n_q <= 1'b1;
    end else begin
      tx_en_q   <= tx_active_i;
      pwr_n_q   <= !(configured_i && !suspend_i);
      sleep_n_q <= !suspend_i;
    end
  end

  assign act_evt = {tx_byte_i | rx_byte_i, rx_byte_i, tx_byte_i};

  for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
    act_stretch #(.HOLD(ACT_HOLD)) u_act (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (act_evt[a]),
      .act_no (act_n[a])
    );
  end

  clk_divider #(.LOW_TAP(DIV_TAP), .NUM_TAPS(CLK_TAPS)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .taps_o (div_taps)
  );

  sync_2ff #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_rd_o)
  );

  always_comb begin
    st.tx_en     = tx_en_q;
    st.pwr_n     = pwr_n_q;
    st.sleep_n   = sleep_n_q;
    st.tx_act_n  = act_n[0];
    st.rx_act_n  = act_n[1];
    st.any_act_n = act_n[2];
    st.clk_div   = div_taps;
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    pin_cell u_cell (
      .code_i     (code_q[k]),
      .st_i       (st),
      .soft_out_i (soft_out_i[k]),
      .soft_oe_i  (soft_oe_i[k]),
      .pin_o      (pin_o[k]),
      .pin_oe_o   (pin_oe_o[k])
    );

    assert_pull_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q[k] == FN_PULL_IN) |-> (!pin_oe_o[k] && pin_o[k]));

    assert_drive_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q[k] == FN_DRV_HI) |-> (pin_oe_o[k] && pin_o[k]));

    assert_drive_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q[k] == FN_DRV_LO) |-> (pin_oe_o[k] && !pin_o[k]));

    assert_soft_io_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q[k] == FN_SOFT_IO) |->
        (pin_o[k] == soft_out_i[k] && pin_oe_o[k] == soft_oe_i[k]));
  end

  assert_code_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rst_q |=> $stable(code_q));

  assert_pwr_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (configured_i && !suspend_i) |=> !st.pwr_n);

  assert_pwr_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> st.pwr_n);
endmodule

// File: tb/pin_func_sel_tb.sv
`timescale 1ns/1ps
module pin_func_sel_tb;
  import pin_func_pkg::*;

  localparam int N    = 10;
  localparam int HOLD = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N*4-1:0]   func_code;
  logic             tx_byte = 0, rx_byte = 0, tx_active = 0, suspend = 0, configured = 0;
  logic [N-1:0]     soft_out = '0, soft_oe = '0, pin_in = '0;
  logic [N-1:0]     pin_o, pin_oe, pin_rd;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_func_sel #(.NUM_PINS(N), .ACT_HOLD(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .func_code_i(func_code),
    .tx_byte_i(tx_byte), .rx_byte_i(rx_byte), .tx_active_i(tx_active),
    .suspend_i(suspend), .configured_i(configured),
    .soft_out_i(soft_out), .soft_oe_i(soft_oe), .pin_in_i(pin_in),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .pin_rd_o(pin_rd)
  );

  // kind: 0 = pin_o, 1 = pin_oe_o, 2 = pin_rd_o
  typedef struct { int at; string req; int pin; int kind; logic exp; } item_t;
  item_t sb[$];

  task automatic push(int dly, string req, int pin, int kind, logic e);
    item_t it;
    int idx;
    it.at = cyc + dly; it.req = req; it.pin = pin; it.kind = kind; it.exp = e;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > it.at) begin idx = i; break; end
    end
    sb.insert(idx, it);
  endtask

  task automatic expect_pin(int dly, string req, int pin, logic o, logic oe);
    push(dly, req, pin, 0, o);
    push(dly, req, pin, 1, oe);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Monitor: compare items due at this sampling point.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic act;
      it = sb.pop_front();
      act = (it.kind == 0) ? pin_o[it.pin] : (it.kind == 1) ? pin_oe[it.pin] : pin_rd[it.pin];
      n_cmp++;
      if (act !== it.exp || it.at != cyc) begin
        n_bad++;
        $display("FAIL %s pin %0d kind %0d cyc %0d: actual %b expected %b",
                 it.req, it.pin, it.kind, cyc, act, it.exp);
      end
    end
  end

  task automatic set_codes(input int c [N]);
    for (int k = 0; k < N; k++) func_code[k*4 +: 4] = 4'(c[k]);
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(3);
    rst_n = 1;
  endtask

  task automatic drain();
    while (sb.size() > 0) tick();
    tick(2);
  endtask

  initial begin
    int c1 [N];
    int c2 [N];
    for (int k = 0; k < N; k++) c1[k] = k;
    c2 = '{10, 11, 12, 14, 15, 0, 0, 0, 0, 0};
    set_codes(c1);
    tick(2);
    do_reset();

    // Reset state
    expect_pin(0, "R2", 0, 1'b1, 1'b0);
    expect_pin(0, "R3", 1, 1'b1, 1'b1);
    expect_pin(0, "R3", 2, 1'b0, 1'b1);
    expect_pin(0, "R6", 4, 1'b0, 1'b1);
    expect_pin(0, "R7", 5, 1'b1, 1'b1);
    expect_pin(0, "R8", 6, 1'b1, 1'b1);
    expect_pin(0, "R8", 7, 1'b1, 1'b1);
    expect_pin(0, "R8", 8, 1'b1, 1'b1);
    expect_pin(0, "R9", 9, 1'b1, 1'b1);
    drain();

    // R4 software I/O; R2 software inputs ignored on pin 0
    soft_out = '1; soft_oe = '1;
    expect_pin(0, "R4", 3, 1'b1, 1'b1);
    expect_pin(0, "R2", 0, 1'b1, 1'b0);
    tick();
    soft_out = '0; soft_oe = '1;
    expect_pin(0, "R4", 3, 1'b0, 1'b1);
    expect_pin(0, "R2", 0, 1'b1, 1'b0);
    tick();
    soft_out = '1; soft_oe = '0;
    expect_pin(0, "R4", 3, 1'b1, 1'b0);
    drain();

    // R5 input synchroniser latency
    pin_in = 10'b10_1010_0101;
    push(1, "R5", 0, 2, 1'b0);
    push(2, "R5", 0, 2, 1'b1);
    push(2, "R5", 1, 2, 1'b0);
    push(2, "R5", 9, 2, 1'b1);
    tick();
    pin_in = '0;
    push(2, "R5", 0, 2, 1'b0);
    push(1, "R5", 9, 2, 1'b1);
    drain();

    // R6 transmit enable
    tx_active = 1;
    push(0, "R6", 4, 0, 1'b0);
    push(1, "R6", 4, 0, 1'b1);
    tick(3);
    tx_active = 0;
    push(0, "R6", 4, 0, 1'b1);
    push(1, "R6", 4, 0, 1'b0);
    drain();

    // R7 power enable, R9 sleep
    configured = 1;
    push(1, "R7", 5, 0, 1'b0);
    tick(2);
    suspend = 1;
    push(0, "R7", 5, 0, 1'b0);
    push(1, "R7", 5, 0, 1'b1);
    push(1, "R9", 9, 0, 1'b0);
    tick(3);
    suspend = 0;
    push(1, "R7", 5, 0, 1'b0);
    push(1, "R9", 9, 0, 1'b1);
    tick(2);
    configured = 0;
    push(1, "R7", 5, 0, 1'b1);
    drain();

    // R8 transmit strobe: pins 6 and 8 low for HOLD cycles, pin 7 untouched
    tx_byte = 1;
    push(0, "R8", 6, 0, 1'b1);
    for (int d = 1; d <= HOLD; d++) begin
      push(d, "R8", 6, 0, 1'b0);
      push(d, "R8", 8, 0, 1'b0);
      push(d, "R8", 7, 0, 1'b1);
    end
    push(HOLD + 1, "R8", 6, 0, 1'b1);
    push(HOLD + 1, "R8", 8, 0, 1'b1);
    tick();
    tx_byte = 0;
    drain();

    // R8 receive strobe with retrigger after 3 cycles
    rx_byte = 1;
    for (int d = 1; d <= 3; d++) begin
      push(d, "R8", 7, 0, 1'b0);
      push(d, "R8", 6, 0, 1'b1);
      push(d, "R8", 8, 0, 1'b0);
    end
    tick();
    rx_byte = 0;
    tick(2);
    rx_byte = 1;
    for (int d = 1; d <= HOLD; d++) begin
      push(d, "R8", 7, 0, 1'b0);
      push(d, "R8", 8, 0, 1'b0);
    end
    push(HOLD + 1, "R8", 7, 0, 1'b1);
    push(HOLD + 1, "R8", 8, 0, 1'b1);
    tick();
    rx_byte = 0;
    drain();

    // Phase 2: clock dividers, unused codes, code capture window
    set_codes(c2);
    do_reset();
    for (int n = 0; n < 40; n++) begin
      expect_pin(n, "R10", 0, 1'((n >> 1) & 1), 1'b1);
      push(n, "R10", 1, 0, 1'((n >> 2) & 1));
      push(n, "R10", 2, 0, 1'((n >> 3) & 1));
    end
    expect_pin(0, "R2", 3, 1'b1, 1'b0);
    expect_pin(0, "R2", 4, 1'b1, 1'b0);
    tick();
    for (int k = 0; k < N; k++) func_code[k*4 +: 4] = 4'd2;
    soft_out = '0; soft_oe = '1;
    expect_pin(4, "R1", 3, 1'b1, 1'b0);
    expect_pin(4, "R1", 4, 1'b1, 1'b0);
    expect_pin(4, "R1", 5, 1'b1, 1'b0);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule